// File: doc/BRIEF.md
# Accumulator Pair Multiply/Divide Unit

This unit performs unsigned multiplication and division using the conventions of an accumulator register pair. The caller presents the current accumulator (low word) and the current high register, an operand, an operation select and a width select. It then pulses `start`. The unit captures these values, iterates one shift-add step (multiply) or one shift-subtract step (divide) per cycle, and returns the new pair. It also returns the carry and overflow flags that the caller should write back.

In byte mode, a multiply takes the low byte of the accumulator times the low byte of the operand, and the 16-bit product replaces the accumulator. A byte divide splits the accumulator by the low operand byte: the quotient goes to the low byte and the remainder to the high byte. In word mode, a multiply produces a 32-bit product across the high:low pair. A word divide uses that pair as the dividend, putting the quotient in the low word and the remainder in the high word. A divisor of zero, or a quotient too wide for its destination, raises `err` and returns the pair unchanged.

`start` acts as a valid strobe whose ready is `!busy`. A strobe while `busy` is high is dropped, not queued, so the caller holds off until `done`. The inputs are sampled only in an accepted `start` cycle. The outputs hold their values until the next completion.

Top module: `muldiv_acc`

## Requirements
- R1: Byte multiply (`op_div`=0, `op_word`=0): `acc_out` = `acc_in[7:0]` * `operand[7:0]`, and `hi_out` = `hi_in`.
- R2: Word multiply (`op_div`=0, `op_word`=1): {`hi_out`,`acc_out`} = `acc_in` * `operand` as a 32-bit product.
- R3: After a multiply, `cf_out` and `of_out` are both 0 when the high half of the product is zero, and both 1 otherwise. The high half is `acc_out[15:8]` in byte mode and `hi_out` in word mode.
- R4: Word divide (`op_div`=1, `op_word`=1): the dividend {`hi_in`,`acc_in`} is divided by `operand`, with the quotient in `acc_out` and the remainder in `hi_out`.
- R5: Byte divide (`op_div`=1, `op_word`=0): `acc_in` is divided by `operand[7:0]`, with the quotient in `acc_out[7:0]`, the remainder in `acc_out[15:8]`, and `hi_out` = `hi_in`.
- R6: A divide, whether it succeeds or fails, leaves `cf_out` and `of_out` unchanged.
- R7: A divide whose upper dividend half (`hi_in` in word mode, `acc_in[15:8]` in byte mode) is greater than or equal to the divisor is a fault. This covers a zero divisor. On a fault, `done` and `err` are both high in the cycle after `start`, `busy` never rises, and `acc_out`/`hi_out` equal `acc_in`/`hi_in`.
- R8: An accepted operation without a fault holds `busy` high for exactly 8 cycles (byte) or 16 cycles (word), starting in the cycle after `start`. `done` is then high for one cycle with `err` low, and the results are valid from that cycle onward.
- R9: A `start` pulse while `busy` is high is ignored: the running operation's result and its cycle count are unaffected.
- R10: After reset, `busy`, `done`, `err`, `cf_out`, `of_out`, `acc_out` and `hi_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, accepted when `busy` is low |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| op_word | input | 1 | 1 = word mode, 0 = byte mode |
| acc_in | input | 16 | Current accumulator (low word) |
| hi_in | input | 16 | Current high register |
| operand | input | 16 | Multiplier or divisor (low byte in byte mode) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Divide fault, valid with `done` |
| acc_out | output | 16 | New accumulator value |
| hi_out | output | 16 | New high register value |
| cf_out | output | 1 | Carry flag result |
| of_out | output | 1 | Overflow flag result |

## Verification
On every cycle, the assertions check the following:
- `done` never coincides with `busy`, and `err` only appears with `done`.
- The step counter counts down even when `start` arrives mid-operation.
- The partial remainder stays below the divisor during a divide, and the byte-multiply partial product never spills above 16 bits.
- The outputs hold steady while iterating, the flags agree with the high product half, and the flags stay put across divides and faults.

Only the bench's scenarios can show the following:
- The actual product, quotient and remainder values for each mode.
- The exact busy length.
- That a dropped mid-run `start` changes nothing.
- The fault boundary where the upper half equals the divisor.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } muldiv_op_e;

  function automatic int steps_for(input int width, input logic word);
    return word ? width : width / 2;
  endfunction
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic word,
  input  logic fault,
  output logic accept,
  output logic step,
  output logic last,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  assign accept = start && !busy;
  assign step   = busy;
  assign last   = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        if (fault) begin
          done <= 1'b1;
          err  <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= CW'(muldiv_pkg::steps_for(W, word));
        end
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R8: completion and iteration never overlap
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: counter stays inside its legal window while iterating
  a_r8_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0) && (cnt <= CW'(W)));

  // R9: a start during busy does not reload the step counter
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt == $past(cnt) - CW'(1)));

  // R9: busy cannot end before the counter runs out
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy && !done);

  // R7: error only reported together with done
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         op_div,
  input  logic         word,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] opnd,
  output logic         is_div,
  output logic         is_word,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         hi_nz
);
  localparam int H = W / 2;

  logic [2*W-1:0] work, work_n, work_ld;
  logic [W-1:0]   aux, aux_ld, opb, opb_ld, hold_hi;
  logic [W:0]     trial, diff;
  logic           ge;
  logic [W-1:0]   rem_n;

  // Load alignment: byte-mode operands are pre-shifted so that the same
  // MSB-first step works for both widths.
  always_comb begin
    if (op_div) begin
      aux_ld = '0;
      if (word) begin
        work_ld = {hi_in, acc_in};
        opb_ld  = opnd;
      end else begin
        work_ld = {{H{1'b0}}, acc_in[W-1:H], acc_in[H-1:0], {H{1'b0}}};
        opb_ld  = {{H{1'b0}}, opnd[H-1:0]};
      end
    end else begin
      work_ld = '0;
      if (word) begin
        aux_ld = opnd;
        opb_ld = acc_in;
      end else begin
        aux_ld = {opnd[H-1:0], {H{1'b0}}};
        opb_ld = {{H{1'b0}}, acc_in[H-1:0]};
      end
    end
  end

  // One iteration: shift-add for multiply, restoring shift-subtract for divide
  always_comb begin
    trial = {work[2*W-1:W], work[W-1]};
    diff  = trial - {1'b0, opb};
    ge    = (trial >= {1'b0, opb});
    rem_n = ge ? diff[W-1:0] : trial[W-1:0];
    if (is_div)
      work_n = {rem_n, work[W-2:0], ge};
    else
      work_n = {work[2*W-2:0], 1'b0} + (aux[W-1] ? {{W{1'b0}}, opb} : {(2*W){1'b0}});
  end

  // Result placement in the register pair, fixed by width mode
  always_comb begin
    hi_nz = is_word ? (|work_n[2*W-1:W]) : (|work_n[W-1:H]);
    if (is_div) begin
      if (is_word) begin
        res_lo = work_n[W-1:0];
        res_hi = work_n[2*W-1:W];
      end else begin
        res_lo = {work_n[W+H-1:W], work_n[H-1:0]};
        res_hi = hold_hi;
      end
    end else begin
      res_lo = work_n[W-1:0];
      res_hi = is_word ? work_n[2*W-1:W] : hold_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work    <= '0;
      aux     <= '0;
      opb     <= '0;
      hold_hi <= '0;
      is_div  <= 1'b0;
      is_word <= 1'b0;
    end else if (load) begin
      work    <= work_ld;
      aux     <= aux_ld;
      opb     <= opb_ld;
      hold_hi <= hi_in;
      is_div  <= op_div;
      is_word <= word;
    end else if (step) begin
      work <= work_n;
      aux  <= {aux[W-2:0], 1'b0};
    end
  end

  // R4: partial remainder stays below the divisor (relies on the fault pre-check)
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_div) |-> (work[2*W-1:W] < opb));

  // R1: byte product never spills above the low word
  a_r1_byte_mul_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !is_div && !is_word) |-> (work[2*W-1:W] == '0));
endmodule

// File: rtl/muldiv_acc.sv
module muldiv_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic         op_word,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] operand,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] hi_out,
  output logic         cf_out,
  output logic         of_out
);
  localparam int H = W / 2;

  logic         accept, step, last, fault;
  logic         is_div, is_word, hi_nz;
  logic [W-1:0] res_lo, res_hi, upper, dvs;

  // Fault pre-check: upper dividend half >= divisor (covers zero divisor)
  always_comb begin
    if (op_word) begin
      upper = hi_in;
      dvs   = operand;
    end else begin
      upper = {{H{1'b0}}, acc_in[W-1:H]};
      dvs   = {{H{1'b0}}, operand[H-1:0]};
    end
    fault = (op_div == muldiv_pkg::OP_DIV) && (upper >= dvs);
  end

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .word(op_word), .fault(fault),
    .accept(accept), .step(step), .last(last), .busy(busy), .done(done), .err(err)
  );

  muldiv_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .op_div(op_div), .word(op_word), .acc_in(acc_in), .hi_in(hi_in), .opnd(operand),
    .is_div(is_div), .is_word(is_word), .res_lo(res_lo), .res_hi(res_hi), .hi_nz(hi_nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      hi_out  <= '0;
      cf_out  <= 1'b0;
      of_out  <= 1'b0;
    end else if (accept && fault) begin
      acc_out <= acc_in;
      hi_out  <= hi_in;
    end else if (last) begin
      acc_out <= res_lo;
      hi_out  <= res_hi;
      if (!is_div) begin
        cf_out <= hi_nz;
        of_out <= hi_nz;
      end
    end
  end

  // R3: multiply flags agree with the high half now sitting in the pair
  a_r3_flags_match_high: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !is_div) |->
      (cf_out == of_out) && (cf_out == (is_word ? (|hi_out) : (|acc_out[W-1:H]))));

  // R6: divide and fault completions keep the flags
  a_r6_div_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err || is_div)) |-> $stable(cf_out) && $stable(of_out));

  // R8: outputs do not move while iterating
  a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(acc_out) && $stable(hi_out));
endmodule

// File: tb/tb_muldiv_acc.sv
module tb_muldiv_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_div = 1'b0, op_word = 1'b0;
  logic [15:0] acc_in = '0, hi_in = '0, operand = '0;
  logic        busy, done, err, cf_out, of_out;
  logic [15:0] acc_out, hi_out;

  int total = 0;
  int bad = 0;
  logic exp_cf = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  muldiv_acc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div), .op_word(op_word),
    .acc_in(acc_in), .hi_in(hi_in), .operand(operand),
    .busy(busy), .done(done), .err(err), .acc_out(acc_out), .hi_out(hi_out),
    .cf_out(cf_out), .of_out(of_out)
  );

  // {div, word, acc, hi, operand}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'hAB12, 16'h5555, 16'h770F},
    {1'b0, 1'b0, 16'hFF07, 16'h1111, 16'hEE09},
    {1'b0, 1'b0, 16'h00FF, 16'h2222, 16'h00FF},
    {1'b1, 1'b0, 16'h1234, 16'h3333, 16'h0056},
    {1'b0, 1'b1, 16'h1234, 16'h4444, 16'h0002},
    {1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF},
    {1'b1, 1'b1, 16'h0000, 16'h0001, 16'h0003},
    {1'b1, 1'b1, 16'h5678, 16'h1234, 16'hABCD},
    {1'b0, 1'b1, 16'h0000, 16'h9999, 16'hABCD},
    {1'b1, 1'b0, 16'h00FF, 16'h6666, 16'h0001},
    {1'b1, 1'b1, 16'h0007, 16'h0000, 16'h0007},
    {1'b0, 1'b0, 16'h0080, 16'h7777, 16'h0002}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic dv, input logic wd, input logic [15:0] a, input logic [15:0] h, input logic [15:0] o);
    @(negedge clk);
    op_div = dv; op_word = wd; acc_in = a; hi_in = h; operand = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc_in = ~a; hi_in = ~h; operand = ~o;
  endtask

  task automatic wait_done(output int nbusy);
    nbusy = 0;
    while (!done && nbusy < 100) begin
      if (busy) nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic expect_op(input logic dv, input logic wd, input logic [15:0] a, input logic [15:0] h,
                           input logic [15:0] o, output logic [15:0] ea, output logic [15:0] eh,
                           output logic ee);
    logic [31:0] p, dd;
    logic [15:0] pb, q16, r16;
    logic [7:0]  q8, r8;
    ee = 1'b0;
    if (!dv) begin
      if (!wd) begin
        pb = {8'h00, a[7:0]} * {8'h00, o[7:0]};
        ea = pb; eh = h; exp_cf = |pb[15:8];
      end else begin
        p = {16'h0, a} * {16'h0, o};
        ea = p[15:0]; eh = p[31:16]; exp_cf = |p[31:16];
      end
    end else if (wd) begin
      if (h >= o) begin ee = 1'b1; ea = a; eh = h; end
      else begin
        dd = {h, a};
        q16 = 16'(dd / {16'h0, o}); r16 = 16'(dd % {16'h0, o});
        ea = q16; eh = r16;
      end
    end else begin
      if (a[15:8] >= o[7:0]) begin ee = 1'b1; ea = a; eh = h; end
      else begin
        q8 = 8'(a / {8'h0, o[7:0]}); r8 = 8'(a % {8'h0, o[7:0]});
        ea = {r8, q8}; eh = h;
      end
    end
  endtask

  task automatic run_and_check(input logic dv, input logic wd, input logic [15:0] a, input logic [15:0] h,
                               input logic [15:0] o, input string tag);
    logic [15:0] ea, eh;
    logic ee;
    int nb, en;
    expect_op(dv, wd, a, h, o, ea, eh, ee);
    issue(dv, wd, a, h, o);
    wait_done(nb);
    en = ee ? 0 : (wd ? 16 : 8);
    check(done == 1'b1, {tag, " R8 done"}, 32'(done), 32'd1);
    check(err == ee, {tag, " R7 err"}, 32'(err), 32'(ee));
    check(nb == en, {tag, " R8 busy cycles"}, 32'(nb), 32'(en));
    check(acc_out == ea, {tag, " acc_out"}, 32'(acc_out), 32'(ea));
    check(hi_out == eh, {tag, " hi_out"}, 32'(hi_out), 32'(eh));
    check(cf_out == exp_cf && of_out == exp_cf, {tag, " R3 R6 flags"}, {cf_out, of_out}, {exp_cf, exp_cf});
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({busy, done, err, cf_out, of_out} == 5'b0, "R10 control outputs", 32'({busy, done, err, cf_out, of_out}), 32'd0);
    check(acc_out == 16'h0 && hi_out == 16'h0, "R10 pair outputs", {acc_out, hi_out}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      string t;
      v = VEC[i];
      if (!v[49]) t = v[48] ? "R2 R3 word mul" : "R1 R3 byte mul";
      else        t = v[48] ? "R4 R6 word div" : "R5 R6 byte div";
      run_and_check(v[49], v[48], v[47:32], v[31:16], v[15:0], t);
    end

    // Make the flags 1 before the fault cases so that R6 is visible
    run_and_check(1'b0, 1'b1, 16'hFFFF, 16'h0, 16'h0002, "R2 R3 flag set");
    run_and_check(1'b1, 1'b1, 16'h1234, 16'h5678, 16'h0000, "R7 R6 word zero divisor");
    run_and_check(1'b1, 1'b0, 16'h5603, 16'hBEEF, 16'h0056, "R7 byte overflow equal");
    run_and_check(1'b1, 1'b1, 16'h0000, 16'h00FF, 16'h00FE, "R7 word overflow");
    run_and_check(1'b1, 1'b0, 16'h5503, 16'hBEEF, 16'h0056, "R5 byte just fits");

    // R9: start while busy is ignored
    begin
      logic [15:0] ea, eh;
      logic ee;
      int nb;
      expect_op(1'b0, 1'b1, 16'h0301, 16'h0, 16'h0205, ea, eh, ee);
      issue(1'b0, 1'b1, 16'h0301, 16'h0, 16'h0205);
      @(negedge clk);
      op_div = 1'b1; op_word = 1'b0; acc_in = 16'h0010; operand = 16'h0003; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(nb);
      check(nb == 14, "R9 busy cycles after mid start", 32'(nb), 32'd14);
      check(acc_out == ea && hi_out == eh, "R9 result untouched", {hi_out, acc_out}, {eh, ea});
      check(err == 1'b0, "R9 no err", 32'(err), 32'd0);
    end

    // R10: reset mid-operation returns to idle
    issue(1'b0, 1'b1, 16'h1111, 16'h0, 16'h2222);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && acc_out == 16'h0 && cf_out == 1'b0, "R10 reset mid-run",
          {busy, cf_out, acc_out}, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule